// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Port

This block is a slave stereo serial audio port. An outside master drives the bit clock and the channel-select (word-select) line. The port never generates either of them. Over one serial data pin it receives a left and a right playback word in every sample period. Over a second pin it sends a left and a right record word in the same period. Both lines run at the rate of the channel-select signal. The port oversamples the serial lines with its own system clock, so the bit clock must be slow compared with that clock.

A static format input selects one of three framings. In I2S framing the MSB arrives one bit slot after the channel-select edge. In MSB-justified framing the MSB arrives in the first slot after the edge. In LSB-justified framing the word is placed against the end of the half-frame. A static length input selects 16, 18 or 20 bits. On the parallel side, each received pair is presented as two left-aligned 20-bit words with a one-cycle strobe. The transmit pair is taken from two 20-bit inputs at the start of each left half-frame.

Top module: `audio_serial_port`

## Requirements
- R1: After reset, `sdata_out` is 0, `rx_valid` and `tx_taken` are 0, and `rx_left` and `rx_right` are zero.
- R2: With `fmt` = 0 (I2S), channel-select low means left and high means right, both delayed by one bit slot. The MSB of each word is in the second slot after a channel-select edge, and the LSB of the previous word is in the slot where the edge occurs.
- R3: With `fmt` = 1 (MSB-justified), channel-select low means left and high means right. The MSB of each word is in the first slot after the edge.
- R4: With `fmt` = 2 or 3 (LSB-justified), the LSB is in the last slot before the next channel-select edge. On transmit, the word is placed using the length of the previous half-frame.
- R5: `len_sel` 0, 1 and 2/3 select 16, 18 and 20 bits. Received words are left-aligned in 20 bits, with unused LSBs zero.
- R6: Slots beyond the word length are ignored on receive and driven as 0 on transmit.
- R7: A half-frame shorter than the word length truncates the word without an error. MSB-framed modes keep the leading bits; LSB-justified mode keeps the trailing bits; the missing bits read as zero.
- R8: `rx_valid` pulses for exactly one cycle per sample period, at the start of the left half-frame that follows a right word. In that cycle `rx_left` and `rx_right` update together, and at no other time.
- R9: Input data is sampled on rising bit-clock edges. `sdata_out` changes only after a falling bit-clock edge and holds through the high phase.
- R10: The transmit pair is captured from `tx_left` and `tx_right` at the start of each left half-frame, and `tx_taken` pulses for one cycle at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt | input | 2 | Framing: 0 I2S, 1 MSB-justified, 2/3 LSB-justified |
| len_sel | input | 2 | Word length: 0 = 16, 1 = 18, 2/3 = 20 bits |
| bclk_in | input | 1 | Bit clock from the master |
| lrclk_in | input | 1 | Channel-select from the master |
| sdata_in | input | 1 | Serial playback data |
| sdata_out | output | 1 | Serial record data |
| tx_left | input | 20 | Left word to transmit, left-aligned |
| tx_right | input | 20 | Right word to transmit, left-aligned |
| tx_taken | output | 1 | One-cycle pulse when the transmit pair is captured |
| rx_left | output | 20 | Last received left word, left-aligned |
| rx_right | output | 20 | Last received right word, left-aligned |
| rx_valid | output | 1 | One-cycle pulse when a received pair is presented |

## Verification
On receive, the rising bit-clock edge that completes a right word is the same edge that delivers the first bit of the next left word. Both the commit of the old word and the start of the new one happen in that one cycle. MSB-justified framing, with its data starting exactly at the channel-select edge, provokes this on every frame, and so do short half-frames where truncation meets the boundary. The bench sweeps every framing, every length and half-frame lengths below, at and above the word length. It judges each received pair against a word computed arithmetically from the bits it sent, and it judges each transmitted slot against the slot window worked out from the requirements.

// File: rtl/asp_pkg.sv
// Package: shared format encoding and word-length decode for the serial audio port.
// Assumes: format and length selects are static while the port runs.
package asp_pkg;
    typedef enum logic [1:0] {
        FMT_I2S     = 2'd0,
        FMT_MSBJ    = 2'd1,
        FMT_LSBJ    = 2'd2,
        FMT_LSBJ_B  = 2'd3
    } fmt_e;

    // Map the length select onto a bit count, clamped to the parallel width.
    function automatic int unsigned word_len(input logic [1:0] sel, input int unsigned width);
        int unsigned n;
        case (sel)
            2'd0:    n = 16;
            2'd1:    n = 18;
            default: n = 20;
        endcase
        return (n > width) ? width : n;
    endfunction
endpackage

// File: rtl/asp_edge_sync.sv
// Module: brings the bit clock, channel-select and data lines into the system clock
// domain through equal-depth flop chains and flags bit-clock edges.
// Assumes: the bit clock half period spans several system clock cycles.
module asp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic lrclk_in,
    input  logic sdata_in,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic lr_s,
    output logic sd_s
);
    logic [STAGES-1:0] bck_p, lr_p, sd_p;
    logic              bck_d;

    // Shift each line through its own chain so all three keep their alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_p <= '0;
            lr_p  <= '0;
            sd_p  <= '0;
            bck_d <= 1'b0;
        end else begin
            bck_p <= {bck_p[STAGES-2:0], bclk_in};
            lr_p  <= {lr_p[STAGES-2:0], lrclk_in};
            sd_p  <= {sd_p[STAGES-2:0], sdata_in};
            bck_d <= bck_p[STAGES-1];
        end
    end

    assign bclk_rise = bck_p[STAGES-1] & ~bck_d;
    assign bclk_fall = ~bck_p[STAGES-1] & bck_d;
    assign lr_s      = lr_p[STAGES-1];
    assign sd_s      = sd_p[STAGES-1];
endmodule

// File: rtl/asp_rx.sv
// Module: deserialiser. It collects bits on rising bit-clock edges, frames them by
// channel-select according to the format and presents left-aligned word pairs.
// Assumes: one rise flag per bit slot, with channel-select and data already synchronised.
module asp_rx
    import asp_pkg::*;
#(
    parameter int W     = 20,
    parameter int CNT_W = 6,
    localparam int IW   = $clog2(W),
    localparam int LW   = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fmt_e          fmt,
    input  logic [LW-1:0] wlen,
    input  logic          rise,
    input  logic          lr,
    input  logic          sd,
    output logic [W-1:0]  rx_left,
    output logic [W-1:0]  rx_right,
    output logic          rx_valid
);
    logic             lr_last, ch;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     acc, sr, hold_left, word_done;
    logic             lr_eff, new_half, lsb_mode;

    assign lsb_mode  = (fmt == FMT_LSBJ) || (fmt == FMT_LSBJ_B);
    assign lr_eff    = (fmt == FMT_I2S) ? lr_last : lr;
    assign new_half  = rise && (lr_eff != ch);
    assign word_done = lsb_mode ? (sr << (LW'(W) - wlen)) : acc;

    // Track the half-frame, assemble the word and commit it at each channel change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_last   <= 1'b0;
            ch        <= 1'b0;
            cnt       <= '0;
            acc       <= '0;
            sr        <= '0;
            hold_left <= '0;
            rx_left   <= '0;
            rx_right  <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rise) begin
                lr_last <= lr;
                if (new_half) begin
                    ch  <= lr_eff;
                    cnt <= CNT_W'(1);
                    acc <= {sd, {(W-1){1'b0}}};
                    sr  <= {{(W-1){1'b0}}, sd};
                    if (!ch) begin
                        hold_left <= word_done;
                    end else begin
                        rx_left  <= hold_left;
                        rx_right <= word_done;
                        rx_valid <= 1'b1;
                    end
                end else begin
                    cnt <= (cnt == '1) ? cnt : cnt + 1'b1;
                    if (cnt < CNT_W'(wlen))
                        acc[IW'(W-1) - IW'(cnt)] <= sd;
                    sr <= {sr[W-2:0], sd};
                end
            end
        end
    end

    // R8
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R8
    rx_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rx_left) || !$stable(rx_right)) |-> rx_valid);
    // R5
    rx_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (((rx_left << wlen) == '0) && ((rx_right << wlen) == '0)));
endmodule

// File: rtl/asp_tx.sv
// Module: serialiser. It moves to the next slot on falling bit-clock edges, captures the
// transmit pair at each left half-frame start and drives zeros outside the word window.
// Assumes: half-frame length is steady; LSB-justified placement uses the previous one.
module asp_tx
    import asp_pkg::*;
#(
    parameter int W       = 20,
    parameter int CNT_W   = 6,
    localparam int IW     = $clog2(W),
    localparam int LW     = $clog2(W + 1),
    localparam int IXW    = CNT_W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fmt_e          fmt,
    input  logic [LW-1:0] wlen,
    input  logic          fall,
    input  logic          lr,
    input  logic [W-1:0]  tx_left,
    input  logic [W-1:0]  tx_right,
    output logic          sdo,
    output logic          tx_taken
);
    logic                  lr_prev, ch, ch_n, lr_t, new_half, lsb_mode, bit_n, in_win;
    logic [CNT_W-1:0]      tcnt, tcnt_n, len_q, len_n, tcnt_inc;
    logic [W-1:0]          wl, wr, word;
    logic signed [IXW-1:0] idx;

    assign lsb_mode = (fmt == FMT_LSBJ) || (fmt == FMT_LSBJ_B);
    assign lr_t     = (fmt == FMT_I2S) ? lr_prev : lr;
    assign new_half = fall && (lr_t != ch);
    assign tcnt_inc = (tcnt == '1) ? tcnt : tcnt + 1'b1;

    // Choose the slot index, the word and the bit for the slot that starts now.
    always_comb begin
        tcnt_n = new_half ? '0 : tcnt_inc;
        len_n  = new_half ? tcnt_inc : len_q;
        ch_n   = new_half ? lr_t : ch;
        if (new_half && !lr_t) word = tx_left;
        else                   word = ch_n ? wr : wl;
        idx    = $signed(IXW'(tcnt_n));
        if (lsb_mode)
            idx = idx + $signed(IXW'(wlen)) - $signed(IXW'(len_n));
        in_win = (idx >= 0) && (idx < $signed(IXW'(wlen)));
        bit_n  = in_win ? word[IW'(W-1) - IW'(idx)] : 1'b0;
    end

    // Advance slot state and update the output bit on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_prev  <= 1'b0;
            ch       <= 1'b1;
            tcnt     <= '0;
            len_q    <= '1;
            wl       <= '0;
            wr       <= '0;
            sdo      <= 1'b0;
            tx_taken <= 1'b0;
        end else begin
            tx_taken <= 1'b0;
            if (fall) begin
                lr_prev <= lr;
                ch      <= ch_n;
                tcnt    <= tcnt_n;
                len_q   <= len_n;
                sdo     <= bit_n;
                if (new_half && !lr_t) begin
                    wl       <= tx_left;
                    wr       <= tx_right;
                    tx_taken <= 1'b1;
                end
            end
        end
    end

    // R9
    tx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(fall));
    // R10
    tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_taken |=> !tx_taken);
    // R10
    tx_take_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_taken |-> $past(fall));
endmodule

// File: rtl/audio_serial_port.sv
// Module: top of the slave serial audio port. It ties the line synchroniser, the
// receive deserialiser and the transmit serialiser to one decoded configuration.
// Assumes: fmt and len_sel change only while the port is held in reset.
module audio_serial_port
    import asp_pkg::*;
#(
    parameter int W           = 20,
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 2,
    localparam int LW         = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   fmt,
    input  logic [1:0]   len_sel,
    input  logic         bclk_in,
    input  logic         lrclk_in,
    input  logic         sdata_in,
    output logic         sdata_out,
    input  logic [W-1:0] tx_left,
    input  logic [W-1:0] tx_right,
    output logic         tx_taken,
    output logic [W-1:0] rx_left,
    output logic [W-1:0] rx_right,
    output logic         rx_valid
);
    logic          rise, fall, lr_s, sd_s;
    logic [LW-1:0] wlen;
    fmt_e          fmt_t;

    assign wlen  = LW'(word_len(len_sel, W));
    assign fmt_t = fmt_e'(fmt);

    asp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .sdata_in(sdata_in), .bclk_rise(rise), .bclk_fall(fall),
        .lr_s(lr_s), .sd_s(sd_s)
    );

    asp_rx #(.W(W), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .fmt(fmt_t), .wlen(wlen), .rise(rise),
        .lr(lr_s), .sd(sd_s), .rx_left(rx_left), .rx_right(rx_right),
        .rx_valid(rx_valid)
    );

    asp_tx #(.W(W), .CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .fmt(fmt_t), .wlen(wlen), .fall(fall),
        .lr(lr_s), .tx_left(tx_left), .tx_right(tx_right),
        .sdo(sdata_out), .tx_taken(tx_taken)
    );
endmodule

// File: tb/test_audio_serial_port.sv
// Bench: acts as the bit-clock master and sweeps format x length x half-frame length.
module test_audio_serial_port;
    localparam int W  = 20;
    localparam int NF = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   fmt = 2'd0, len_sel = 2'd0;
    logic         bclk_in = 1'b1, lrclk_in = 1'b0, sdata_in = 1'b0;
    logic         sdata_out, tx_taken, rx_valid;
    logic [W-1:0] tx_left = '0, tx_right = '0, rx_left, rx_right;

    int  n_cmp = 0, n_bad = 0, rxv_cnt = 0, take_cnt = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    audio_serial_port i_audio_serial_port (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .len_sel(len_sel),
        .bclk_in(bclk_in), .lrclk_in(lrclk_in), .sdata_in(sdata_in),
        .sdata_out(sdata_out), .tx_left(tx_left), .tx_right(tx_right),
        .tx_taken(tx_taken), .rx_left(rx_left), .rx_right(rx_right),
        .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) rxv_cnt++;
        if (rst_n && tx_taken) take_cnt++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int f, input int ch, input int salt);
        logic [31:0] x;
        x = 32'h9E3779B9 * (f * 2 + ch + 1) ^ (32'(salt) * 32'h85EBCA6B);
        return x[27:8];
    endfunction

    function automatic int slot_idx(input int mode, input int wl, input int len, input int b);
        return (mode >= 2) ? b + wl - len : b;
    endfunction

    function automatic logic [W-1:0] exp_rx(input logic [W-1:0] w, input int mode,
                                            input int wl, input int len);
        logic [W-1:0] r = '0;
        for (int k = 0; k < W; k++)
            if (k < wl && ((mode >= 2) ? (k >= wl - len) : (k < len)))
                r[W-1-k] = w[W-1-k];
        return r;
    endfunction

    task automatic run_cfg(input int mode, input int ls, input int len, input int salt);
        int    wl, idx, nb;
        bit    win, wsv, ebit;
        string req;
        wl = (ls == 0) ? 16 : (ls == 1) ? 18 : 20;
        req = (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
        @(negedge clk);
        fmt = 2'(mode); len_sel = 2'(ls); bclk_in = 1'b1; lrclk_in = 1'b0; sdata_in = 1'b0;
        tx_left = pat(0, 0, salt + 50); tx_right = pat(0, 1, salt + 50);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rxv_cnt = 0; take_cnt = 0;
        for (int f = 0; f <= NF; f++) begin
            for (int ch = 0; ch < ((f == NF) ? 1 : 2); ch++) begin
                nb = (f == NF) ? 2 : len;
                for (int b = 0; b < nb; b++) begin
                    wsv  = (mode == 0 && b == len - 1) ? !ch[0] : ch[0];
                    idx  = slot_idx(mode, wl, len, b);
                    win  = (idx >= 0) && (idx < wl);
                    bclk_in  = 1'b0;
                    lrclk_in = wsv;
                    // R6: slots outside the window carry ones that must be ignored
                    sdata_in = win ? pat(f, ch, salt)[W-1-idx] : 1'b1;
                    if (ch == 1 && b == len / 2 && f < NF) begin
                        tx_left  = pat(f + 1, 0, salt + 50);
                        tx_right = pat(f + 1, 1, salt + 50);
                    end
                    repeat (8) @(negedge clk);
                    ebit = win ? pat(f, ch, salt + 50)[W-1-idx] : 1'b0;
                    if (f >= 1 && f < NF)
                        check(!win ? "R6 tx pad" : (len < wl) ? "R7 tx trunc" : req,
                              32'(sdata_out), 32'(ebit));
                    if (f >= 2 && ch == 0 && b == 1) begin
                        check((len < wl) ? "R7 rx left" : "R5 rx left", 32'(rx_left),
                              32'(exp_rx(pat(f - 1, 0, salt), mode, wl, len)));
                        check((len < wl) ? "R7 rx right" : "R5 rx right", 32'(rx_right),
                              32'(exp_rx(pat(f - 1, 1, salt), mode, wl, len)));
                    end
                    bclk_in = 1'b1;
                    repeat (4) @(negedge clk);
                    // R9: output holds through the high phase
                    if (f >= 1 && f < NF) check("R9 hold", 32'(sdata_out), 32'(ebit));
                    repeat (4) @(negedge clk);
                end
            end
        end
        repeat (6) @(negedge clk);
        check("R8 pulses", 32'(rxv_cnt), 32'(NF));
        check("R10 captures", 32'(take_cnt), 32'(NF + 1));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int lens[4];
        int cfg;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 sdo", 32'(sdata_out), 32'd0);
        check("R1 valid", 32'({rx_valid, tx_taken}), 32'd0);
        check("R1 left", 32'(rx_left), 32'd0);
        check("R1 right", 32'(rx_right), 32'd0);
        cfg = 0;
        for (int m = 0; m < 3; m++)
            for (int ls = 0; ls < 3; ls++) begin
                lens[0] = 14; lens[1] = (ls == 0) ? 16 : (ls == 1) ? 18 : 20;
                lens[2] = 24; lens[3] = 32;
                for (int k = 0; k < 4; k++) begin
                    run_cfg(m, ls, lens[k], cfg);
                    cfg++;
                end
            end
        // R4: encoding 3 behaves as LSB-justified, length select 3 as 20 bits
        run_cfg(3, 3, 24, cfg);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule